// File: doc/BRIEF.md
# Time Base Dual-Compare Interrupt Unit

This block keeps a free-running time base counter that advances on an external tick strobe. Two reference registers are compared against the counter every cycle. Each reference has a sticky status bit that records a match and an enable bit that lets that match raise an interrupt. The two enabled matches merge into one interrupt request. A service routine reads the status bits to learn which reference fired. It then clears those bits by writing ones to them.

The merged request is placed on one of eight priority level lines toward the interrupt controller. The line is chosen by an 8-bit one-hot level pattern. The most significant bit selects level 0 and the least significant bit selects level 7. A binary level number is not a valid pattern. A pattern with no bit set, or with more than one bit set, drives no line at all.

All registers are reached through a plain single-cycle register port. A write is taken on the clock edge where `wr_en` is high. Read data is a combinational function of `addr`. The port carries control and status only, so it has no valid/ready handshake and never applies back-pressure.

Top module: `tbcmp_top`

## Requirements
- R1: After reset the counter reads 0, both references read all ones, both enables and both status bits read 0, the level pattern reads 0, and `irq_req` and every `irq_line` bit are low.
- R2: On each clock edge with `tick` high and no counter write, the counter increases by one and wraps from all ones to 0. Without `tick` it holds its value.
- R3: A write to address 0 loads the counter, and the new value reads back on the next cycle. If a tick arrives on the same edge, the write takes precedence over the increment.
- R4: Status bit n (bit 0 = reference A, bit 1 = reference B at address 4) is set on the edge that follows a cycle in which the counter equals reference n. This happens whether or not enable n is set. Once set, the bit stays set.
- R5: Writing address 4 clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged. If a match occurs on the same edge as the clear, the bit stays set.
- R6: `irq_req` is high exactly when (status A and enable A) or (status B and enable B) holds. Enable A is bit 0 and enable B is bit 1 at address 3.
- R7: When the level pattern at address 5 has exactly one bit set, at bit position 7-k, `irq_line[k]` follows `irq_req` and all other lines stay low. So 0x80 drives line 0, 0x40 drives line 1, 0x20 drives line 2, and 0x01 drives line 7.
- R8: A level pattern with zero bits set or with two or more bits set (for example a binary value such as 0x03) keeps every `irq_line` bit low, even while `irq_req` is high.
- R9: Address 1 holds reference A and address 2 holds reference B. Reads of addresses 6 and 7 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | CNT_W | Register write data |
| rdata | output | CNT_W | Register read data for `addr` |
| irq_req | output | 1 | Merged interrupt request |
| irq_line | output | NUM_LVL | Level lines, index = level number |

## Verification
The bench builds the unit with an 8-bit counter. The references and the counter write path keep their full behaviour at that width. The narrow counter lets a wrap from all ones to zero be reached within a few ticks of a written value. Both references and all eight level lines are kept at their default counts. This lets the bench walk every one-hot position and several invalid patterns against a held request.

// File: rtl/tbcmp_pkg.sv
package tbcmp_pkg;
  typedef enum logic [2:0] {
    RA_COUNT  = 3'd0,
    RA_REF_A  = 3'd1,
    RA_REF_B  = 3'd2,
    RA_ENABLE = 3'd3,
    RA_STATUS = 3'd4,
    RA_LEVEL  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/tbcmp_counter.sv
module tbcmp_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (load)   count <= load_val;
    else if (tick)   count <= count + ONE;
  end
endmodule

// File: rtl/tbcmp_ref_unit.sv
module tbcmp_ref_unit #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             ref_we,
  input  logic [CNT_W-1:0] ref_wval,
  input  logic             en_we,
  input  logic             en_wval,
  input  logic             st_clr,
  output logic [CNT_W-1:0] ref_val,
  output logic             en,
  output logic             st,
  output logic             req
);
  logic hit;

  assign hit = (count == ref_val);
  assign req = st & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_val <= '1;
      en      <= 1'b0;
      st      <= 1'b0;
    end else begin
      if (ref_we) ref_val <= ref_wval;
      if (en_we)  en      <= en_wval;
      st <= (st & ~st_clr) | hit;
    end
  end
endmodule

// File: rtl/tbcmp_level_steer.sv
module tbcmp_level_steer #(
  parameter int NUM_LVL = 8
) (
  input  logic               req,
  input  logic [NUM_LVL-1:0] level,
  output logic [NUM_LVL-1:0] line
);
  logic single;

  assign single = (level != '0) && ((level & (level - NUM_LVL'(1))) == '0);

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_line
    assign line[k] = req & single & level[NUM_LVL-1-k];
  end
endmodule

// File: rtl/tbcmp_top.sv
module tbcmp_top
  import tbcmp_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_LVL = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               wr_en,
  input  logic [2:0]         addr,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   rdata,
  output logic               irq_req,
  output logic [NUM_LVL-1:0] irq_line
);
  localparam int NUM_REF = 2;

  logic [CNT_W-1:0]              cnt_q;
  logic [NUM_REF-1:0][CNT_W-1:0] ref_q;
  logic [NUM_REF-1:0]            en_q;
  logic [NUM_REF-1:0]            st_q;
  logic [NUM_REF-1:0]            req_v;
  logic [NUM_LVL-1:0]            level_q;

  logic wr_cnt, wr_en_reg, wr_st, wr_lvl;

  assign wr_cnt    = wr_en && (addr == RA_COUNT);
  assign wr_en_reg = wr_en && (addr == RA_ENABLE);
  assign wr_st     = wr_en && (addr == RA_STATUS);
  assign wr_lvl    = wr_en && (addr == RA_LEVEL);

  tbcmp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (wr_cnt),
    .load_val (wdata),
    .count    (cnt_q)
  );

  for (genvar n = 0; n < NUM_REF; n++) begin : g_ref
    tbcmp_ref_unit #(.CNT_W(CNT_W)) u_ref (
      .clk      (clk),
      .rst_n    (rst_n),
      .count    (cnt_q),
      .ref_we   (wr_en && (addr == 3'(int'(RA_REF_A) + n))),
      .ref_wval (wdata),
      .en_we    (wr_en_reg),
      .en_wval  (wdata[n]),
      .st_clr   (wr_st && wdata[n]),
      .ref_val  (ref_q[n]),
      .en       (en_q[n]),
      .st       (st_q[n]),
      .req      (req_v[n])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      level_q <= '0;
    else if (wr_lvl) level_q <= wdata[NUM_LVL-1:0];
  end

  assign irq_req = |req_v;

  tbcmp_level_steer #(.NUM_LVL(NUM_LVL)) u_steer (
    .req   (irq_req),
    .level (level_q),
    .line  (irq_line)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      RA_COUNT:  rdata = cnt_q;
      RA_REF_A:  rdata = ref_q[0];
      RA_REF_B:  rdata = ref_q[1];
      RA_ENABLE: rdata[NUM_REF-1:0] = en_q;
      RA_STATUS: rdata[NUM_REF-1:0] = st_q;
      RA_LEVEL:  rdata[NUM_LVL-1:0] = level_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/tbcmp_chk.sv
module tbcmp_chk
  import tbcmp_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_LVL = 8,
  parameter int NUM_REF = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          tick,
  input logic                          wr_en,
  input logic [2:0]                    addr,
  input logic [CNT_W-1:0]              wdata,
  input logic [CNT_W-1:0]              cnt,
  input logic [NUM_REF-1:0][CNT_W-1:0] refs,
  input logic [NUM_REF-1:0]            st,
  input logic [NUM_LVL-1:0]            level,
  input logic                          irq_req,
  input logic [NUM_LVL-1:0]            irq_line
);
  logic cnt_wr;
  assign cnt_wr = wr_en && (addr == RA_COUNT);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> (cnt == $past(cnt) + CNT_W'(1))); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wdata))); // R3
  AST_LINE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_line)); // R7
  AST_NO_REQ_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_line == '0)); // R7
  AST_BAD_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(level) != 1) |-> (irq_line == '0)); // R8

  for (genvar n = 0; n < NUM_REF; n++) begin : g_chk
    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == refs[n]) |=> st[n]); // R4
  end
endmodule

bind tbcmp_top tbcmp_chk #(.CNT_W(CNT_W), .NUM_LVL(NUM_LVL), .NUM_REF(NUM_REF)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .cnt      (cnt_q),
  .refs     (ref_q),
  .st       (st_q),
  .level    (level_q),
  .irq_req  (irq_req),
  .irq_line (irq_line)
);

// File: tb/tbcmp_top_tb.sv
module tbcmp_top_tb;
  localparam int CW = 8;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    addr = 3'd0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic          irq_req;
  logic [NL-1:0] irq_line;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tbcmp_top #(.CNT_W(CW), .NUM_LVL(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_req(irq_req), .irq_line(irq_line)
  );

  // level pattern -> expected lines, request held high
  localparam int NV = 12;
  localparam logic [15:0] LVL_VEC [NV] = '{
    16'h80_01, 16'h40_02, 16'h20_04, 16'h10_08,
    16'h08_10, 16'h04_20, 16'h02_40, 16'h01_80,
    16'h00_00, 16'h03_00, 16'hC0_00, 16'hFF_00
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [CW-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [CW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 count", v, 0);
    rd(3'd1, v); check("R1 refA", v, 8'hFF);
    rd(3'd2, v); check("R1 refB", v, 8'hFF);
    rd(3'd3, v); check("R1 enable", v, 0);
    rd(3'd4, v); check("R1 status", v, 0);
    rd(3'd5, v); check("R1 level", v, 0);
    check("R1 irq", {irq_req, irq_line}, 0);

    // hold a request: count parked at ref A, enable A
    wr(3'd1, 8'h05);
    wr(3'd0, 8'h05);
    wr(3'd3, 8'h01);
    @(negedge clk);
    check("R6 req high", irq_req, 1);

    // R7 / R8 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(3'd5, LVL_VEC[i][15:8]);
      #1;
      check((LVL_VEC[i][7:0] != 0) ? "R7 level line" : "R8 bad level",
            irq_line, LVL_VEC[i][7:0]);
    end
    wr(3'd5, 8'h80);

    // R5 match wins over clear while parked on ref A
    wr(3'd4, 8'h01);
    rd(3'd4, v); check("R5 set wins", v, 8'h01);
    // move off, then clear with 0 (no effect) and with 1
    wr(3'd0, 8'h40);
    wr(3'd4, 8'h00);
    rd(3'd4, v); check("R5 write0 keeps", v, 8'h01);
    wr(3'd4, 8'h01);
    rd(3'd4, v); check("R5 w1c", v, 8'h00);
    #1; check("R6 req low", irq_req, 0);
    check("R7 line low", irq_line, 0);

    // R3 write beats tick on the same edge
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 3'd0; wdata = 8'h10;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(3'd0, v); check("R3 load over tick", v, 8'h10);

    // R2 increments and wrap
    ticks(4);
    rd(3'd0, v); check("R2 inc", v, 8'h14);
    repeat (3) @(negedge clk);
    rd(3'd0, v); check("R2 hold", v, 8'h14);
    wr(3'd0, 8'hFE);
    ticks(3);
    rd(3'd0, v); check("R2 wrap", v, 8'h01);

    // R4 status on ref B while disabled, R6 gating by enable
    wr(3'd3, 8'h00);
    wr(3'd2, 8'h20);
    rd(3'd2, v); check("R9 refB", v, 8'h20);
    wr(3'd0, 8'h1E);
    ticks(2);
    wr(3'd0, 8'h60);
    rd(3'd4, v); check("R4 status B disabled", v, 8'h02);
    #1; check("R6 no req disabled", irq_req, 0);
    wr(3'd3, 8'h02);
    #1; check("R6 req via B", irq_req, 1);
    check("R7 line0 via B", irq_line, 8'h01);
    wr(3'd5, 8'h01);
    #1; check("R7 line7", irq_line, 8'h80);

    // R9 unused addresses
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'hFF);
    rd(3'd6, v); check("R9 read6", v, 0);
    rd(3'd7, v); check("R9 read7", v, 0);
    rd(3'd0, v); check("R9 count untouched", v, 8'h60);
    rd(3'd1, v); check("R9 refA untouched", v, 8'h05);
    rd(3'd4, v); check("R9 status untouched", v, 8'h02);

    finish_run();
  end
endmodule